// File: doc/BRIEF.md
# Coordinated Multi-Axis Step Pulse Generator

This block drives the step and direction pins of a group of stepper motors that must arrive together. The axis with the largest step count becomes the lead. A step tick, whose period follows the lead's current velocity, steps the lead on every tick. Each other axis keeps an error accumulator and steps on some of those ticks, so that its average rate is its count's share of the lead rate and it finishes on the lead's last tick.

Every pulse rises on a tick. Its falling edge is scheduled by adding the pulse width to a free-running counter and comparing against the sum. A slower acceleration event raises the velocity by a fixed amount, up to a ceiling, and a sequential divider turns the new velocity into a new tick period while the move runs. A done flag reports that the lead has issued all of its steps and the last pulse has fallen.

Top module: `coord_step_gen`

## Requirements
- R1: On `start`, the axis with the largest count in `steps_in` becomes the lead (on a tie, the lowest index wins). The lead pulses on every tick and issues exactly its count of pulses.
- R2: Every other axis issues exactly its own count of pulses. On each tick it adds its count to an accumulator that starts at half the lead count. It pulses when the sum reaches the lead count, and the lead count is then subtracted.
- R3: A rising edge on any `step_o` bit falls in the same cycle as a rising edge of the lead's bit.
- R4: Each pulse stays high for exactly `pulse_w` clock cycles, and a `pulse_w` of 0 acts as 1. `pulse_w` is latched at `start` and must be below the tick period.
- R5: `dir_o[i]` copies `dir_in[i]` at `start`, with 1 on the input giving 1 on the pin. It holds through the move whatever `dir_in` does, and it never changes in a cycle that has a rising step edge.
- R6: The first tick interval of a move is `CLK_HZ / v` cycles, where v is `v_start` limited to `v_max`.
- R7: Every `ACC_CYC` cycles of running, the velocity grows by `accel` and saturates at `v_max`. The tick period then becomes `CLK_HZ / velocity`, so a long move settles at an interval of `CLK_HZ / v_max`.
- R8: `done` clears at an accepted `start` and sets once the lead's last pulse has fallen. A move whose counts are all zero sets `done` with no pulse. `step_o` is all zero whenever `done` is high.
- R9: After reset, `step_o`, `dir_o` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a move (accepted when idle) |
| steps_in | input | NAX*CNT_W | Per-axis step counts, axis i at bits [i*CNT_W +: CNT_W] |
| dir_in | input | NAX | Per-axis direction, latched at start |
| pulse_w | input | PW_W | Step pulse high time in cycles |
| v_start | input | VEL_W | Start velocity in steps per second |
| v_max | input | VEL_W | Velocity ceiling in steps per second |
| accel | input | VEL_W | Velocity increment per acceleration event |
| step_o | output | NAX | Step pulse outputs |
| dir_o | output | NAX | Direction outputs |
| done | output | 1 | Move complete |

## Verification
The bench checks ties in lead choice, where picking the wrong axis would starve another axis of steps. It checks axes with counts of one and zero, which an accumulator with a wrong start value or a wrong compare would step the wrong number of times. It checks a zero pulse width, which a compare taken literally would stretch across the whole counter wrap, and a direction input that toggles mid-move, which an unlatched direction would pass straight to the pins. It also checks a long move that must settle at the velocity ceiling, which would show up as too short an interval if the clamp were missing. It checks an all-zero move that must finish without pulsing, where a design with no guard would hang.

// File: rtl/csg_pkg.sv
package csg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DIV   = 2'd1,
      ST_RUN   = 2'd2,
      ST_DRAIN = 2'd3
   } run_st_t;
endpackage

// File: rtl/csg_div.sv
// Restoring divider: period = DVD / divisor, one quotient bit per cycle.
module csg_div #(
   parameter int DVD   = 125_000_000,
   parameter int VEL_W = 20,
   parameter int PER_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [VEL_W-1:0] divisor,
   output logic             fin,
   output logic [PER_W-1:0] quot
);
   localparam int DW = $clog2(DVD + 1);
   localparam int CW = $clog2(DW + 1);

   logic [VEL_W-1:0] rem, dv;
   logic [DW-1:0]    sh, q;
   logic [CW-1:0]    n;
   logic             run;
   logic [VEL_W:0]   rem_sh;
   logic             ge;

   always_comb begin
      rem_sh = {rem, sh[DW-1]};
      ge     = rem_sh >= {1'b0, dv};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem <= '0; dv <= '0; sh <= '0; q <= '0; n <= '0;
         run <= 1'b0; fin <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            rem <= '0;
            dv  <= divisor;
            sh  <= DW'(DVD);
            q   <= '0;
            n   <= CW'(DW);
            run <= 1'b1;
         end else if (run) begin
            rem <= ge ? VEL_W'(rem_sh - {1'b0, dv}) : rem_sh[VEL_W-1:0];
            sh  <= sh << 1;
            q   <= {q[DW-2:0], ge};
            n   <= n - 1'b1;
            if (n == CW'(1)) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end

   generate
      if (DW > PER_W) begin : g_sat
         assign quot = (|q[DW-1:PER_W]) ? '1 : q[PER_W-1:0];
      end else begin : g_wide
         assign quot = PER_W'(q);
      end
   endgenerate
endmodule

// File: rtl/csg_ramp.sv
// Velocity register with clamp and the fixed-interval acceleration event.
module csg_ramp #(
   parameter int VEL_W   = 20,
   parameter int ACC_CYC = 625_000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run_en,
   input  logic [VEL_W-1:0] v_start,
   input  logic [VEL_W-1:0] v_max,
   input  logic [VEL_W-1:0] accel,
   output logic [VEL_W-1:0] vel,
   output logic [VEL_W-1:0] vmax_q,
   output logic             acc_evt
);
   localparam int ACW = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;

   logic [ACW-1:0]   cnt;
   logic [VEL_W-1:0] acc_q, vmx, vst;
   logic [VEL_W:0]   vsum;

   always_comb begin
      vmx  = (v_max == '0) ? VEL_W'(1) : v_max;
      vst  = (v_start == '0) ? VEL_W'(1) : v_start;
      vsum = {1'b0, vel} + {1'b0, acc_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vel <= '0; vmax_q <= '0; acc_q <= '0; cnt <= '0; acc_evt <= 1'b0;
      end else begin
         acc_evt <= 1'b0;
         if (load) begin
            vmax_q <= vmx;
            acc_q  <= accel;
            vel    <= (vst > vmx) ? vmx : vst;
            cnt    <= '0;
         end else if (run_en) begin
            if (cnt == ACW'(ACC_CYC - 1)) begin
               cnt     <= '0;
               acc_evt <= 1'b1;
               vel     <= (vsum > {1'b0, vmax_q}) ? vmax_q : vsum[VEL_W-1:0];
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/csg_axis.sv
// Per-axis error accumulator deciding whether the axis steps on a tick.
module csg_axis #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] total_in,
   input  logic [CNT_W-1:0] half_in,
   input  logic [CNT_W-1:0] lead_tot,
   input  logic             tick,
   output logic             fire
);
   logic [CNT_W-1:0] acc, tot_q;
   logic [CNT_W:0]   sum, rest;
   logic             hit;

   always_comb begin
      sum  = {1'b0, acc} + {1'b0, tot_q};
      hit  = sum >= {1'b0, lead_tot};
      rest = sum - {1'b0, lead_tot};
      fire = tick && hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc <= '0; tot_q <= '0;
      end else if (load) begin
         acc   <= half_in;
         tot_q <= total_in;
      end else if (tick) begin
         acc <= hit ? rest[CNT_W-1:0] : sum[CNT_W-1:0];
      end
   end
endmodule

// File: rtl/coord_step_gen.sv
module coord_step_gen
   import csg_pkg::*;
#(
   parameter int NAX     = 4,
   parameter int CNT_W   = 16,
   parameter int VEL_W   = 20,
   parameter int PER_W   = 20,
   parameter int PW_W    = 8,
   parameter int CLK_HZ  = 125_000_000,
   parameter int ACC_CYC = 625_000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [NAX*CNT_W-1:0] steps_in,
   input  logic [NAX-1:0]       dir_in,
   input  logic [PW_W-1:0]      pulse_w,
   input  logic [VEL_W-1:0]     v_start,
   input  logic [VEL_W-1:0]     v_max,
   input  logic [VEL_W-1:0]     accel,
   output logic [NAX-1:0]       step_o,
   output logic [NAX-1:0]       dir_o,
   output logic                 done
);
   localparam int DIV_W = $clog2(CLK_HZ + 1);

   generate
      if (NAX < 1 || NAX > 10) begin : g_bad_nax
         $error("NAX must be 1..10");
      end
      if (ACC_CYC < DIV_W + 4) begin : g_bad_acc
         $error("ACC_CYC must exceed the divider latency");
      end
      if (PW_W < 1 || CNT_W < 2 || VEL_W < 2 || PER_W < 2) begin : g_bad_w
         $error("width parameters too small");
      end
   endgenerate

   run_st_t          st;
   logic [CNT_W-1:0] lead_c, lead_r, left;
   logic [NAX-1:0]   lead_oh_c, lead_oh, fire;
   logic [PER_W-1:0] period_r, tcnt, quot;
   logic [PER_W:0]   tnext;
   logic [PW_W-1:0]  fr_cnt, cmp_r, pw_r;
   logic             pend, kick, tick, ld, div_fin, acc_evt;
   logic [VEL_W-1:0] vel, vmax_q;

   // lead search: largest count, lowest index on a tie
   always_comb begin
      lead_c    = '0;
      lead_oh_c = '0;
      for (int i = 0; i < NAX; i++) begin
         if (steps_in[i*CNT_W +: CNT_W] > lead_c) begin
            lead_c    = steps_in[i*CNT_W +: CNT_W];
            lead_oh_c = NAX'(1) << i;
         end
      end
      if (lead_c == '0) lead_oh_c = NAX'(1);
   end

   assign ld    = (st == ST_IDLE) && start;
   assign tnext = {1'b0, tcnt} + {{PER_W{1'b0}}, 1'b1};
   assign tick  = (st == ST_RUN) && (tnext >= {1'b0, period_r});

   csg_ramp #(.VEL_W(VEL_W), .ACC_CYC(ACC_CYC)) u_ramp (
      .clk(clk), .rst_n(rst_n), .load(ld), .run_en(st == ST_RUN),
      .v_start(v_start), .v_max(v_max), .accel(accel),
      .vel(vel), .vmax_q(vmax_q), .acc_evt(acc_evt)
   );

   csg_div #(.DVD(CLK_HZ), .VEL_W(VEL_W), .PER_W(PER_W)) u_div (
      .clk(clk), .rst_n(rst_n), .go(kick || acc_evt), .divisor(vel),
      .fin(div_fin), .quot(quot)
   );

   generate
      for (genvar a = 0; a < NAX; a++) begin : g_ax
         csg_axis #(.CNT_W(CNT_W)) u_ax (
            .clk(clk), .rst_n(rst_n), .load(ld),
            .total_in(steps_in[a*CNT_W +: CNT_W]),
            .half_in(lead_c >> 1), .lead_tot(lead_r),
            .tick(tick), .fire(fire[a])
         );
      end
   endgenerate

   // sequencing and tick period
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; lead_r <= '0; left <= '0; lead_oh <= '0;
         period_r <= '1; tcnt <= '0; kick <= 1'b0; dir_o <= '0;
         done <= 1'b0; pw_r <= PW_W'(1);
      end else begin
         kick <= 1'b0;
         if (div_fin) period_r <= (quot == '0) ? PER_W'(1) : quot;
         case (st)
            ST_IDLE: if (start) begin
               dir_o   <= dir_in;
               lead_r  <= lead_c;
               left    <= lead_c;
               lead_oh <= lead_oh_c;
               pw_r    <= (pulse_w == '0) ? PW_W'(1) : pulse_w;
               done    <= 1'b0;
               if (lead_c != '0) begin
                  kick <= 1'b1;
                  st   <= ST_DIV;
               end else begin
                  st <= ST_DRAIN;
               end
            end
            ST_DIV: if (div_fin) begin
               tcnt <= '0;
               st   <= ST_RUN;
            end
            ST_RUN: begin
               tcnt <= tick ? '0 : tnext[PER_W-1:0];
               if (tick) begin
                  left <= left - 1'b1;
                  if (left == CNT_W'(1)) st <= ST_DRAIN;
               end
            end
            default: if (!pend) begin
               done <= 1'b1;
               st   <= ST_IDLE;
            end
         endcase
      end
   end

   // shared edge handler: rising edges on tick, trailing edges on compare
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fr_cnt <= '0; cmp_r <= '0; pend <= 1'b0; step_o <= '0;
      end else begin
         fr_cnt <= fr_cnt + 1'b1;
         if (tick && (|fire)) begin
            step_o <= fire;
            cmp_r  <= fr_cnt + pw_r;
            pend   <= 1'b1;
         end else if (pend && (fr_cnt == cmp_r)) begin
            step_o <= '0;
            pend   <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/csg_chk.sv
module csg_chk #(
   parameter int NAX   = 4,
   parameter int VEL_W = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NAX-1:0]   step_o,
   input logic [NAX-1:0]   dir_o,
   input logic             done,
   input logic             tick,
   input logic [NAX-1:0]   lead_oh,
   input logic             running,
   input logic [VEL_W-1:0] vel,
   input logic [VEL_W-1:0] vmax_q
);
   p_rise_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|(step_o & ~$past(step_o))) |-> $past(tick));

   p_lead_every_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (|(step_o & lead_oh)));

   p_dir_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|(step_o & ~$past(step_o))) |-> $stable(dir_o));

   p_vel_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (vel <= vmax_q && vel != '0));

   p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (step_o == '0));
endmodule

bind coord_step_gen csg_chk #(.NAX(NAX), .VEL_W(VEL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .step_o(step_o), .dir_o(dir_o), .done(done),
   .tick(tick), .lead_oh(lead_oh), .running(st == csg_pkg::ST_RUN),
   .vel(vel), .vmax_q(vmax_q)
);

// File: tb/test_coord_step_gen.sv
`timescale 1ns/1ps
module test_coord_step_gen;
   localparam int NAX = 4, CNT_W = 16, VEL_W = 20, PW_W = 8;
   localparam int CLK_HZ = 1_000_000, ACC_CYC = 400;
   localparam int VS = 10_000, VM = 50_000, VA = 5_000;
   localparam int NV = 4;
   localparam int V_ST [NV][NAX] = '{'{12, 5, 0, 12}, '{8, 3, 7, 1},
                                     '{1, 1, 1, 1}, '{300, 150, 299, 1}};
   localparam int V_DIR [NV] = '{4'b1010, 4'b0110, 4'b1111, 4'b0001};
   localparam int V_PW  [NV] = '{5, 1, 0, 10};

   logic clk = 0, rst_n = 0, start = 0;
   logic [NAX*CNT_W-1:0] steps_in = '0;
   logic [NAX-1:0] dir_in = '0, step_o, dir_o;
   logic [PW_W-1:0] pulse_w = '0;
   logic [VEL_W-1:0] v_start = VEL_W'(VS), v_max = VEL_W'(VM), accel = VEL_W'(VA);
   logic done;

   int n_chk = 0, n_bad = 0;
   int rises [NAX];
   int hi_len [NAX];
   int wid_err, sync_err, dir_err, exp_pw, lead_i, cyc, lead_n;
   int t_prev, first_int, last_int;
   logic [NAX-1:0] prev_step, exp_dir;

   always #4 clk = ~clk;

   coord_step_gen #(.NAX(NAX), .CNT_W(CNT_W), .VEL_W(VEL_W), .PER_W(20),
      .PW_W(PW_W), .CLK_HZ(CLK_HZ), .ACC_CYC(ACC_CYC)) i_coord_step_gen (
      .clk(clk), .rst_n(rst_n), .start(start), .steps_in(steps_in),
      .dir_in(dir_in), .pulse_w(pulse_w), .v_start(v_start), .v_max(v_max),
      .accel(accel), .step_o(step_o), .dir_o(dir_o), .done(done));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // edge monitor, sampled at the falling clock edge
   always @(negedge clk) begin
      cyc++;
      for (int i = 0; i < NAX; i++) begin
         if (step_o[i] && !prev_step[i]) begin
            rises[i]++;
            hi_len[i] = 1;
            if (dir_o !== exp_dir) dir_err++;
            if (!step_o[lead_i] || prev_step[lead_i]) sync_err++;
         end else if (step_o[i]) begin
            hi_len[i]++;
         end else if (prev_step[i] && hi_len[i] != exp_pw) begin
            wid_err++;
         end
      end
      if (step_o[lead_i] && !prev_step[lead_i]) begin
         lead_n++;
         if (lead_n == 2) first_int = cyc - t_prev;
         last_int = cyc - t_prev;
         t_prev = cyc;
      end
      prev_step = step_o;
   end

   task automatic run_move(input int v);
      int lmax, to;
      lmax = 0; lead_i = 0;
      for (int i = 0; i < NAX; i++) begin
         steps_in[i*CNT_W +: CNT_W] = CNT_W'(V_ST[v][i]);
         if (V_ST[v][i] > lmax) begin lmax = V_ST[v][i]; lead_i = i; end
         rises[i] = 0; hi_len[i] = 0;
      end
      dir_in  = NAX'(V_DIR[v]);
      exp_dir = NAX'(V_DIR[v]);
      pulse_w = PW_W'(V_PW[v]);
      exp_pw  = (V_PW[v] == 0) ? 1 : V_PW[v];
      wid_err = 0; sync_err = 0; dir_err = 0; lead_n = 0;
      first_int = 0; last_int = 0; t_prev = cyc;
      start = 1;
      @(negedge clk);
      start  = 0;
      dir_in = ~dir_in;  // R5: must have no effect on the pins
      to = 0;
      while (!done && to < 40000) begin @(negedge clk); to++; end
      chk(done === 1'b1, "R8 done after move", done, 1);
      chk(rises[lead_i] == lmax, "R1 lead pulse count", rises[lead_i], lmax);
      for (int i = 0; i < NAX; i++)
         if (i != lead_i)
            chk(rises[i] == V_ST[v][i], "R2 slave pulse count", rises[i], V_ST[v][i]);
      chk(sync_err == 0, "R3 rise without lead rise", sync_err, 0);
      chk(wid_err == 0, "R4 pulse width errors", wid_err, 0);
      chk(dir_err == 0 && dir_o == exp_dir, "R5 direction held", dir_o, exp_dir);
      if (lmax >= 2)
         chk(first_int == CLK_HZ / VS, "R6 first tick interval", first_int, CLK_HZ / VS);
      if (lmax >= 200)
         chk(last_int == CLK_HZ / VM, "R7 settled tick interval", last_int, CLK_HZ / VM);
      @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      prev_step = '0; exp_dir = '0; cyc = 0; lead_i = 0; exp_pw = 1;
      repeat (3) @(negedge clk);
      chk(step_o == '0 && dir_o == '0 && done == 1'b0, "R9 reset state",
          {step_o, dir_o, done}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(done == 1'b0 && step_o == '0, "R9 idle after reset", {step_o, done}, 0);
      for (int v = 0; v < NV; v++) run_move(v);
      // R8: all-zero move finishes with no pulse
      steps_in = '0;
      for (int i = 0; i < NAX; i++) rises[i] = 0;
      start = 1;
      @(negedge clk);
      start = 0;
      chk(done == 1'b0, "R8 done clears on start", done, 0);
      repeat (4) @(negedge clk);
      chk(done == 1'b1, "R8 zero move done", done, 1);
      chk(rises[0] + rises[1] + rises[2] + rises[3] == 0, "R8 zero move pulses",
          rises[0] + rises[1] + rises[2] + rises[3], 0);
      // R6: start velocity above ceiling is clamped to v_max
      v_start = VEL_W'(80_000);
      v_max   = VEL_W'(25_000);
      for (int i = 0; i < NAX; i++) rises[i] = 0;
      steps_in = '0;
      steps_in[0 +: CNT_W] = CNT_W'(3);
      lead_i = 0; lead_n = 0; exp_pw = 2; pulse_w = PW_W'(2); t_prev = cyc;
      exp_dir = dir_in;
      start = 1;
      @(negedge clk);
      start = 0;
      while (!done) @(negedge clk);
      chk(first_int == CLK_HZ / 25_000, "R6 clamped start interval", first_int,
          CLK_HZ / 25_000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule